// File: doc/BRIEF.md
# Packetized Mesh Line Checker

This block protects the logic underneath a bank of parallel top-layer wires. It takes a stream of keystream words, writes each word onto one group of wires (a packet), reads the same group back at the far end, and compares what arrived with its own delayed copy of the word. A packet index rotates over all packets, one step per accepted word, so over time every wire carries fresh unpredictable data and every wire is checked. A cut, a stuck wire, an inverted wire or a short between two wires shows up as a difference between the sent and received bits.

Each packet has its own sticky mismatch bit. Together these bits show where the tampering happened. The single alarm output is raised as long as any of them is set. The status bits stay set until software pulses the clear input. The wires themselves are outside the block: the transmit lines leave on one port and the received lines come back on another. Between the two ports there is only wiring, or the injected faults of a bench.

The keystream arrives on a valid/ready interface. The block holds ready high whenever it is enabled and low when it is disabled, so the only back-pressure comes from the enable. A producer must hold its word and valid until it sees ready. With the default parameters there are 640 lines, split into 5 packets of 128 lines each. When the line count is not a multiple of the word width, the last packet is narrower.

Top module: `mesh_line_checker`

## Requirements
- R1: `ks_ready` equals `en` in every cycle. A word is accepted at a rising clock edge where both `ks_valid` and `ks_ready` are high.
- R2: The packet index is 0 after reset and advances by one for each accepted word. After packet NPKT-1 it wraps to 0. NPKT = ceil(LINES/WORD_W).
- R3: A word accepted with index p drives its bit i onto `mesh_tx[p*WORD_W + i]` from that edge onwards. The lines of all other packets keep their values, and the lines do not change at an edge without an acceptance.
- R4: The last packet carries only LINES-(NPKT-1)*WORD_W lines. The upper word bits are neither sent nor compared, so they never cause a mismatch.
- R5: At the second rising edge after a word is accepted, the lines of its packet captured from `mesh_rx` one edge earlier are compared with the word. Any differing bit sets `pkt_status[p]`. A full match leaves the status unchanged.
- R6: Status bits are sticky. `alarm` is high exactly when any status bit is set.
- R7: `clr` high at an edge clears all status bits. A mismatch detected at that same edge still sets its bit.
- R8: While `en` is low, no words are accepted and no comparisons are made. A word still in flight when `en` falls is discarded without being compared, and `mesh_tx` holds its value.
- R9: After reset, `pkt_status`, `alarm` and all of `mesh_tx` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enables transmission and checking |
| clr | input | 1 | Clears all sticky status bits |
| ks_valid | input | 1 | Keystream word valid |
| ks_ready | output | 1 | Block accepts a keystream word |
| ks_data | input | WORD_W | Keystream word |
| mesh_tx | output | LINES | Driven ends of the shield lines |
| mesh_rx | input | LINES | Received ends of the shield lines |
| pkt_status | output | NPKT | Sticky per-packet mismatch bits |
| alarm | output | 1 | OR of all status bits |

## Verification
The assertions assume that `rst_n` is held low through the first clock edge. They also assume that `mesh_rx` is a function of `mesh_tx` alone, so the received lines only change when a transmit register loads. The bench builds every fault (inversion, stuck level, short to another line) as a combinational function of `mesh_tx`, and it changes the fault setting only at falling edges. Words are spaced by at least one idle cycle in the sweeps, so that each capture sees settled lines and the expected status can be computed from a line model in the bench.

// File: rtl/mlc_pkg.sv
package mlc_pkg;

  // number of packets needed to cover all lines
  function automatic int pkt_count(input int lines, input int w);
    return (lines + w - 1) / w;
  endfunction

  // number of lines actually present in packet p
  function automatic int pkt_width(input int lines, input int w, input int p);
    int rem;
    rem = lines - p * w;
    return (rem < w) ? rem : w;
  endfunction

  // index width, never zero
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mlc_tx_bank.sv
module mlc_tx_bank #(
  parameter int LINES  = 640,
  parameter int WORD_W = 128,
  localparam int NPKT  = mlc_pkg::pkt_count(LINES, WORD_W),
  localparam int IDX_W = mlc_pkg::idx_bits(NPKT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] word,
  output logic [NPKT-1:0]   tx_load,
  output logic [LINES-1:0]  mesh_tx
);

  for (genvar p = 0; p < NPKT; p++) begin : g_pkt
    localparam int PW = mlc_pkg::pkt_width(LINES, WORD_W, p);
    logic [PW-1:0] q;

    assign tx_load[p] = load && (idx == IDX_W'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= '0;
      else if (tx_load[p]) q <= word[PW-1:0];
    end

    assign mesh_tx[p*WORD_W +: PW] = q;
  end

endmodule

// File: rtl/mlc_rx_select.sv
module mlc_rx_select #(
  parameter int LINES  = 640,
  parameter int WORD_W = 128,
  localparam int NPKT  = mlc_pkg::pkt_count(LINES, WORD_W),
  localparam int IDX_W = mlc_pkg::idx_bits(NPKT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic [LINES-1:0]  mesh_rx,
  output logic [WORD_W-1:0] rx_word
);

  logic [NPKT-1:0][WORD_W-1:0] slices;
  logic [WORD_W-1:0]           picked;

  // zero-extend each packet of lines to a full word
  for (genvar p = 0; p < NPKT; p++) begin : g_slice
    localparam int PW = mlc_pkg::pkt_width(LINES, WORD_W, p);
    assign slices[p] = WORD_W'(mesh_rx[p*WORD_W +: PW]);
  end

  always_comb begin
    picked = '0;
    for (int p = 0; p < NPKT; p++) begin
      if (sel_idx == IDX_W'(p)) picked = slices[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rx_word <= '0;
    else if (capture) rx_word <= picked;
  end

endmodule

// File: rtl/mlc_compare_status.sv
module mlc_compare_status #(
  parameter int LINES  = 640,
  parameter int WORD_W = 128,
  localparam int NPKT  = mlc_pkg::pkt_count(LINES, WORD_W),
  localparam int IDX_W = mlc_pkg::idx_bits(NPKT),
  localparam int LAST_W = mlc_pkg::pkt_width(LINES, WORD_W, NPKT - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_valid,
  input  logic [IDX_W-1:0]  chk_idx,
  input  logic [WORD_W-1:0] rx_word,
  input  logic [WORD_W-1:0] exp_word,
  input  logic              clr,
  output logic [NPKT-1:0]   status
);

  logic [WORD_W-1:0] lane_mask;
  logic              miss;
  logic [NPKT-1:0]   hit;

  // only lanes that exist in the selected packet take part
  always_comb begin
    for (int i = 0; i < WORD_W; i++) begin
      lane_mask[i] = (chk_idx != IDX_W'(NPKT - 1)) || (i < LAST_W);
    end
  end

  assign miss = |((rx_word ^ exp_word) & lane_mask);

  always_comb begin
    for (int p = 0; p < NPKT; p++) begin
      hit[p] = chk_valid && miss && (chk_idx == IDX_W'(p));
    end
  end

  // a new mismatch wins over a clear at the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (clr ? '0 : status) | hit;
  end

endmodule

// File: rtl/mesh_line_checker.sv
module mesh_line_checker #(
  parameter int LINES  = 640,
  parameter int WORD_W = 128,
  localparam int NPKT  = mlc_pkg::pkt_count(LINES, WORD_W),
  localparam int IDX_W = mlc_pkg::idx_bits(NPKT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr,
  input  logic              ks_valid,
  output logic              ks_ready,
  input  logic [WORD_W-1:0] ks_data,
  output logic [LINES-1:0]  mesh_tx,
  input  logic [LINES-1:0]  mesh_rx,
  output logic [NPKT-1:0]   pkt_status,
  output logic              alarm
);

  logic              accept;
  logic [IDX_W-1:0]  pkt_idx;
  logic [NPKT-1:0]   tx_load;

  // stage 1: word on the lines; stage 2: lines captured
  logic              s1_valid, s2_valid;
  logic [IDX_W-1:0]  s1_idx, s2_idx;
  logic [WORD_W-1:0] s1_word, s2_word;
  logic [WORD_W-1:0] rx_word;
  logic              chk_valid;

  assign ks_ready  = en;
  assign accept    = ks_valid && ks_ready;
  assign chk_valid = s2_valid && en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_idx <= '0;
    end else if (accept) begin
      pkt_idx <= (pkt_idx == IDX_W'(NPKT - 1)) ? '0 : pkt_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
      s1_idx   <= '0;
      s2_idx   <= '0;
      s1_word  <= '0;
      s2_word  <= '0;
    end else begin
      s1_valid <= accept;
      s2_valid <= s1_valid && en;
      if (accept) begin
        s1_idx  <= pkt_idx;
        s1_word <= ks_data;
      end
      if (s1_valid) begin
        s2_idx  <= s1_idx;
        s2_word <= s1_word;
      end
    end
  end

  mlc_tx_bank #(.LINES(LINES), .WORD_W(WORD_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .idx     (pkt_idx),
    .word    (ks_data),
    .tx_load (tx_load),
    .mesh_tx (mesh_tx)
  );

  mlc_rx_select #(.LINES(LINES), .WORD_W(WORD_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (s1_valid && en),
    .sel_idx (s1_idx),
    .mesh_rx (mesh_rx),
    .rx_word (rx_word)
  );

  mlc_compare_status #(.LINES(LINES), .WORD_W(WORD_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_valid (chk_valid),
    .chk_idx   (s2_idx),
    .rx_word   (rx_word),
    .exp_word  (s2_word),
    .clr       (clr),
    .status    (pkt_status)
  );

  assign alarm = |pkt_status;

endmodule

// File: rtl/mlc_checker.sv
module mlc_checker #(
  parameter int LINES  = 640,
  parameter int WORD_W = 128,
  localparam int NPKT  = mlc_pkg::pkt_count(LINES, WORD_W),
  localparam int IDX_W = mlc_pkg::idx_bits(NPKT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             clr,
  input logic             accept,
  input logic [IDX_W-1:0] pkt_idx,
  input logic [NPKT-1:0]  tx_load,
  input logic             chk_valid,
  input logic [LINES-1:0] mesh_tx,
  input logic [NPKT-1:0]  pkt_status,
  input logic             alarm
);

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_idx <= IDX_W'(NPKT - 1)); // R2

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> pkt_idx == (($past(pkt_idx) == IDX_W'(NPKT - 1)) ? '0 : $past(pkt_idx) + 1'b1)); // R2

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(pkt_idx)); // R2

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_load)); // R3

  AST_LINES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(mesh_tx)); // R3

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    alarm && !clr |=> alarm); // R6

  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !chk_valid |=> pkt_status == '0); // R7

  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !clr |=> $stable(pkt_status)); // R8

endmodule

bind mesh_line_checker mlc_checker #(.LINES(LINES), .WORD_W(WORD_W)) i_mlc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .clr        (clr),
  .accept     (accept),
  .pkt_idx    (pkt_idx),
  .tx_load    (tx_load),
  .chk_valid  (chk_valid),
  .mesh_tx    (mesh_tx),
  .pkt_status (pkt_status),
  .alarm      (alarm)
);

// File: tb/test_mesh_line_checker.sv
module test_mesh_line_checker;

  localparam int LINES = 40;
  localparam int W     = 16;
  localparam int NP    = 3;
  localparam int CLK_PERIOD = 10;

  // fault kinds
  localparam int T_NONE  = 0;
  localparam int T_FLIP  = 1;
  localparam int T_STUCK = 2;
  localparam int T_SHORT = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic             clr = 1'b0;
  logic             ks_valid = 1'b0;
  logic             ks_ready;
  logic [W-1:0]     ks_data = '0;
  logic [LINES-1:0] mesh_tx;
  logic [LINES-1:0] mesh_rx;
  logic [NP-1:0]    pkt_status;
  logic             alarm;

  int   t_mode = T_NONE;
  int   t_a = 0;
  int   t_b = 0;
  logic t_v = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [LINES-1:0] m_lines = '0;
  logic [NP-1:0]    m_status = '0;
  int               bidx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mesh_line_checker #(.LINES(LINES), .WORD_W(W)) i_mesh_line_checker (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr),
    .ks_valid(ks_valid), .ks_ready(ks_ready), .ks_data(ks_data),
    .mesh_tx(mesh_tx), .mesh_rx(mesh_rx),
    .pkt_status(pkt_status), .alarm(alarm)
  );

  function automatic logic fault_line(input int l, input logic [LINES-1:0] src,
                                      input int mode, input int a, input int b,
                                      input logic v);
    if (l != a) return src[l];
    case (mode)
      T_FLIP:  return ~src[l];
      T_STUCK: return v;
      T_SHORT: return src[b];
      default: return src[l];
    endcase
  endfunction

  always_comb begin
    for (int l = 0; l < LINES; l++)
      mesh_rx[l] = fault_line(l, mesh_tx, t_mode, t_a, t_b, t_v);
  end

  function automatic logic [W-1:0] word_of(input int k);
    return W'(k * 40503 + 12345) ^ W'(k << 7);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one word, then one idle cycle; returns at the falling edge after capture
  task automatic send(input logic [W-1:0] w, input bit judged);
    @(negedge clk);
    ks_valid = 1'b1;
    ks_data  = w;
    @(negedge clk);
    ks_valid = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (bidx * W + i < LINES) m_lines[bidx * W + i] = w[i];
    end
    if (judged) begin
      for (int i = 0; i < W; i++) begin
        int l;
        l = bidx * W + i;
        if (l < LINES && fault_line(l, m_lines, t_mode, t_a, t_b, t_v) != m_lines[l])
          m_status[bidx] = 1'b1;
      end
    end
    bidx = (bidx + 1) % NP;
    @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    m_status = '0;
  endtask

  task automatic one_round(input int seed);
    for (int k = 0; k < NP; k++) send(word_of(seed * NP + k), 1'b1);
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [LINES-1:0] snap;

    repeat (3) @(negedge clk);
    check("R9", "status after reset", 64'(pkt_status), 64'd0);
    check("R9", "alarm after reset", 64'(alarm), 64'd0);
    check("R9", "lines after reset", 64'(mesh_tx), 64'd0);
    check("R1", "ready while disabled", 64'(ks_ready), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    check("R1", "ready while enabled", 64'(ks_ready), 64'd1);

    // line mapping and rotation, no faults
    send(16'h1234, 1'b1); settle();
    check("R3", "packet 0 lines", 64'(mesh_tx[15:0]), 64'h1234);
    check("R3", "other packets untouched", 64'(mesh_tx[39:16]), 64'd0);
    send(16'hBEEF, 1'b1); settle();
    check("R3", "packet 1 lines", 64'(mesh_tx[31:16]), 64'hBEEF);
    check("R3", "packet 0 kept", 64'(mesh_tx[15:0]), 64'h1234);
    send(16'hC3A5, 1'b1); settle();
    check("R4", "narrow packet lines", 64'(mesh_tx[39:32]), 64'hA5);
    check("R4", "dropped bits not compared", 64'(pkt_status), 64'd0);
    send(16'h0F0F, 1'b1); settle();
    check("R2", "index wraps to packet 0", 64'(mesh_tx[15:0]), 64'h0F0F);
    check("R2", "packet 1 kept on wrap", 64'(mesh_tx[31:16]), 64'hBEEF);

    // inversion of each line in turn
    for (int l = 0; l < LINES; l++) begin
      t_mode = T_FLIP; t_a = l;
      one_round(l);
      check("R5", $sformatf("flip line %0d", l), 64'(pkt_status), 64'(1 << (l / W)));
      t_mode = T_NONE;
      clear_all();
    end

    // sticky status after the fault is removed
    t_mode = T_FLIP; t_a = 20;
    one_round(100);
    t_mode = T_NONE;
    one_round(101);
    check("R6", "status kept after fault gone", 64'(pkt_status), 64'b010);
    check("R6", "alarm follows status", 64'(alarm), 64'd1);
    clear_all();
    @(negedge clk);
    check("R7", "clear empties status", 64'(pkt_status), 64'd0);
    check("R6", "alarm low with empty status", 64'(alarm), 64'd0);

    // every line stuck at each level
    for (int l = 0; l < LINES; l++) begin
      for (int v = 0; v < 2; v++) begin
        t_mode = T_STUCK; t_a = l; t_v = v[0];
        one_round(200 + 2 * l + v);
        check("R5", $sformatf("stuck line %0d at %0d", l, v), 64'(pkt_status), 64'(m_status));
        t_mode = T_NONE;
        clear_all();
      end
    end

    // shorts between line pairs
    for (int a = 0; a < LINES; a++) begin
      t_mode = T_SHORT; t_a = a; t_b = (a * 7 + 3) % LINES;
      if (t_b == a) t_b = (a + 1) % LINES;
      one_round(400 + a);
      check("R5", $sformatf("short %0d<-%0d", t_a, t_b), 64'(pkt_status), 64'(m_status));
      t_mode = T_NONE;
      clear_all();
    end

    // mismatch wins over clear at the same edge
    clr = 1'b1;
    t_mode = T_FLIP; t_a = bidx * W;
    begin
      int p;
      p = bidx;
      send(16'h5A5A, 1'b1);
      @(negedge clk);
      check("R7", "set wins over clear", 64'(pkt_status), 64'(1 << p));
      @(negedge clk);
      check("R7", "clear after the set edge", 64'(pkt_status), 64'd0);
    end
    clr = 1'b0;
    m_status = '0;
    t_mode = T_NONE;

    // disabled: nothing accepted, nothing compared
    @(negedge clk);
    en = 1'b0;
    t_mode = T_FLIP; t_a = 0;
    snap = mesh_tx;
    @(negedge clk);
    check("R1", "ready drops with enable", 64'(ks_ready), 64'd0);
    ks_valid = 1'b1; ks_data = 16'hFFFF;
    repeat (6) @(negedge clk);
    ks_valid = 1'b0;
    check("R8", "lines held while disabled", 64'(mesh_tx), 64'(snap));
    check("R8", "no check while disabled", 64'(pkt_status), 64'd0);

    // word in flight when enable falls is discarded
    en = 1'b1;
    t_a = bidx * W;
    send(16'h3C3C, 1'b0);
    en = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", "in-flight word discarded", 64'(pkt_status), 64'd0);
    check("R8", "alarm quiet after discard", 64'(alarm), 64'd0);
    t_mode = T_NONE;
    en = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule